// File: doc/BRIEF.md
# Self-checking carry-select adder

This block adds two unsigned operands and a carry-in without a clock. Two ripple chains of compressor cells work side by side. One chain assumes a carry-in of zero and the other a carry-in of one. The real carry-in then picks which chain drives the sum and the carry-out.

Alongside the addition, the block checks itself continuously. A separate AND chain over the bitwise propagate terms predicts where the two chains should disagree. Each bit position, plus the pair of chain carry-outs, forms a complementary two-rail pair that is valid only while the prediction holds. A balanced tree of two-rail checker cells folds these pairs into one 2-bit error word. The values 01 and 10 mean healthy. The values 00 and 11 mean a fault somewhere in the adder or in the checker tree.

A fault-injection input pins any one internal net to a chosen level. A test environment uses it to show that single stuck-at faults are caught during normal operation.

Top module: `scsa_adder`

## Requirements
- R1: With injection off, `{carryOut, sum}` equals `opA + opB + carryIn` computed at WIDTH+1 bits.
- R2: With injection off, `errPair` is always 01 or 10, for every operand and carry-in value.
- R3: When `opB` is the bitwise inverse of `opA` and `carryIn` is 0, every bit of `sum` is 1 and `carryOut` is 0.
- R4: When `opB` is the bitwise inverse of `opA` and `carryIn` is 1, every bit of `sum` is 0 and `carryOut` is 1.
- R5: For fixed operands, toggling `carryIn` flips exactly those sum bits whose incoming carry changes: the low run of bit positions below and including the first position where `opA` and `opB` are equal.
- R6: Injection addresses net `5*i + k` for bit `i`, where k=0 is the carry-0 chain sum, k=1 the carry-1 chain sum, k=2 the carry-0 chain carry out of bit i, k=3 the carry-1 chain carry out of bit i, and k=4 the propagate-AND output above bit i. With `faultEn` high, forcing any such net to either level makes `errPair` read 00 or 11 for at least one input vector.
- R7: While `faultEn` is 0, `faultNet` and `faultStuck` have no effect on `sum`, `carryOut` or `errPair`.
- R8: An injection index at or beyond `5*WIDTH` touches no net, so the outputs behave as in R1 and R2 even with `faultEn` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0; selects the chain |
| faultEn | input | 1 | Enables stuck-at injection |
| faultStuck | input | 1 | Level forced onto the chosen net |
| faultNet | input | 10 | Index of the net to force (encoding in R6) |
| sum | output | WIDTH | Selected sum |
| carryOut | output | 1 | Selected carry-out |
| errPair | output | 2 | Two-rail error word; 01 or 10 means healthy |

## Verification
The addition and the self-check act on the same vector in the same cycle. A fault in the chain that `carryIn` does not select can leave the sum correct while the error word still has to turn invalid. The bench therefore sweeps every injectable net at both stuck levels over vectors with both carry-in values. For each fault it requires at least one invalid error word. On fault-free vectors it compares sum, carry-out and error validity against a behavioural model on every clock. It also pairs equal operands across the two carry-in values to confirm the exact set of flipped sum bits.

// File: rtl/scsa_pkg.sv
package scsa_pkg;
  localparam int FAULT_IDX_W  = 10;
  localparam int NETS_PER_BIT = 5;
  localparam int K_S0   = 0;
  localparam int K_S1   = 1;
  localparam int K_C0   = 2;
  localparam int K_C1   = 3;
  localparam int K_PROP = 4;

  typedef struct packed {
    logic                   en;
    logic                   stuck;
    logic [FAULT_IDX_W-1:0] net;
  } faultCtl_t;

  function automatic logic inject(input logic v, input faultCtl_t fc, input int idx);
    return (fc.en && (int'(fc.net) == idx)) ? fc.stuck : v;
  endfunction
endpackage

// File: rtl/scsa_cell.sv
module scsa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic halfX;
  assign halfX = a ^ b;
  assign s     = halfX ^ ci;
  assign co    = halfX ? ci : b;
endmodule

// File: rtl/scsa_dual_chain.sv
module scsa_dual_chain
  import scsa_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  faultCtl_t        fc,
  output logic [WIDTH-1:0] sum0,
  output logic [WIDTH-1:0] sum1,
  output logic             cout0,
  output logic             cout1,
  output logic [WIDTH-1:0] expDiff,
  output logic             allProp
);
  logic [WIDTH:0] c0Net;
  logic [WIDTH:0] c1Net;
  logic [WIDTH:0] propPath;

  assign c0Net[0]    = 1'b0;
  assign c1Net[0]    = 1'b1;
  assign propPath[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int BASE = NETS_PER_BIT * i;
    logic s0Raw, c0Raw, s1Raw, c1Raw;

    scsa_cell u_cellLo (.a(opA[i]), .b(opB[i]), .ci(c0Net[i]), .s(s0Raw), .co(c0Raw));
    scsa_cell u_cellHi (.a(opA[i]), .b(opB[i]), .ci(c1Net[i]), .s(s1Raw), .co(c1Raw));

    assign sum0[i]       = inject(s0Raw, fc, BASE + K_S0);
    assign sum1[i]       = inject(s1Raw, fc, BASE + K_S1);
    assign c0Net[i+1]    = inject(c0Raw, fc, BASE + K_C0);
    assign c1Net[i+1]    = inject(c1Raw, fc, BASE + K_C1);
    assign propPath[i+1] = inject(propPath[i] & (opA[i] ^ opB[i]), fc, BASE + K_PROP);
  end

  assign cout0   = c0Net[WIDTH];
  assign cout1   = c1Net[WIDTH];
  assign expDiff = propPath[WIDTH-1:0];
  assign allProp = propPath[WIDTH];
endmodule

// File: rtl/scsa_rail_cell.sv
module scsa_rail_cell (
  input  logic [1:0] pa,
  input  logic [1:0] pb,
  output logic [1:0] pz
);
  assign pz[0] = (pa[0] & pb[0]) | (pa[1] & pb[1]);
  assign pz[1] = (pa[0] & pb[1]) | (pa[1] & pb[0]);
endmodule

// File: rtl/scsa_rail_tree.sv
module scsa_rail_tree #(
  parameter int PAIRS = 17
) (
  input  logic [PAIRS-1:0] railHi,
  input  logic [PAIRS-1:0] railLo,
  output logic [1:0]       errPair
);
  localparam int LEAVES = 1 << $clog2(PAIRS);
  localparam int NODES  = 2 * LEAVES - 1;

  logic [1:0] node [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < PAIRS) begin : g_real
      assign node[LEAVES-1+j] = {railHi[j], railLo[j]};
    end else begin : g_pad
      assign node[LEAVES-1+j] = 2'b01;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    scsa_rail_cell u_cell (.pa(node[2*k+1]), .pb(node[2*k+2]), .pz(node[k]));
  end

  assign errPair = node[0];
endmodule

// File: rtl/scsa_adder.sv
module scsa_adder
  import scsa_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]       opA,
  input  logic [WIDTH-1:0]       opB,
  input  logic                   carryIn,
  input  logic                   faultEn,
  input  logic                   faultStuck,
  input  logic [FAULT_IDX_W-1:0] faultNet,
  output logic [WIDTH-1:0]       sum,
  output logic                   carryOut,
  output logic [1:0]             errPair
);
  localparam int PAIRS = WIDTH + 1;

  faultCtl_t        fc;
  logic [WIDTH-1:0] sum0, sum1, expDiff;
  logic             cout0, cout1, allProp;
  logic [PAIRS-1:0] railHi, railLo;

  assign fc = '{en: faultEn, stuck: faultStuck, net: faultNet};

  scsa_dual_chain #(.WIDTH(WIDTH)) u_chain (
    .opA(opA), .opB(opB), .fc(fc),
    .sum0(sum0), .sum1(sum1), .cout0(cout0), .cout1(cout1),
    .expDiff(expDiff), .allProp(allProp)
  );

  assign sum      = carryIn ? sum1 : sum0;
  assign carryOut = carryIn ? cout1 : cout0;

  assign railHi = {cout1 ^ cout0, sum1 ^ sum0};
  assign railLo = {~allProp, ~expDiff};

  scsa_rail_tree #(.PAIRS(PAIRS)) u_tree (
    .railHi(railHi), .railLo(railLo), .errPair(errPair)
  );
endmodule

// File: rtl/scsa_adder_sva.sv
module scsa_adder_sva
  import scsa_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0]       opA,
  input logic [WIDTH-1:0]       opB,
  input logic                   carryIn,
  input logic                   faultEn,
  input logic                   faultStuck,
  input logic [FAULT_IDX_W-1:0] faultNet,
  input logic [WIDTH-1:0]       sum,
  input logic                   carryOut,
  input logic [1:0]             errPair
);
  logic [WIDTH:0] refTotal;
  assign refTotal = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    if (!faultEn) begin
      assert_sum_R1: assert ({carryOut, sum} == refTotal);
      assert_rail_valid_R2: assert (errPair[1] ^ errPair[0]);
      if (opB == ~opA && !carryIn) begin
        assert_inv_ones_R3: assert (sum == {WIDTH{1'b1}} && !carryOut);
      end
      if (opB == ~opA && carryIn) begin
        assert_inv_zeros_R4: assert (sum == {WIDTH{1'b0}} && carryOut);
      end
    end
  end
endmodule

bind scsa_adder scsa_adder_sva #(.WIDTH(WIDTH)) u_sva (.*);

// File: tb/scsa_adder_tb.sv
module scsa_adder_tb;
  localparam int W        = 16;
  localparam int PERIOD   = 10;
  localparam int FW       = scsa_pkg::FAULT_IDX_W;
  localparam int NETS     = 5 * W;
  localparam int MAXCYC   = 150000;
  localparam int FVECS    = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0]  opA = '0, opB = '0;
  logic          carryIn = 1'b0, faultEn = 1'b0, faultStuck = 1'b0;
  logic [FW-1:0] faultNet = '0;
  logic [W-1:0]  sum;
  logic          carryOut;
  logic [1:0]    errPair;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  scsa_adder #(.WIDTH(W)) u_dut (
    .opA(opA), .opB(opB), .carryIn(carryIn), .faultEn(faultEn),
    .faultStuck(faultStuck), .faultNet(faultNet),
    .sum(sum), .carryOut(carryOut), .errPair(errPair)
  );

  task automatic fin();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAXCYC) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, MAXCYC);
      fin();
    end
  end

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
    @(negedge clk);
    opA = a; opB = b; carryIn = ci;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic checkVec(input string tag);
    logic [W:0] exp;
    exp = {1'b0, opA} + {1'b0, opB} + {{W{1'b0}}, carryIn};
    check({carryOut, sum} == exp, {tag, " sum"}, 64'({carryOut, sum}), 64'(exp));
    check(errPair[1] ^ errPair[0], {tag, " err"}, 64'(errPair), 64'h1);
  endtask

  initial begin
    logic [W-1:0] a, b, sLo, sHi, expFlip;
    bit hit;

    repeat (3) @(posedge clk);
    #1;
    check(sum == '0 && !carryOut, "R1 reset-state sum", 64'({carryOut, sum}), 64'h0);
    check(errPair == 2'b10, "R2 reset-state err", 64'(errPair), 64'h2);
    rstN = 1'b1;

    for (int v = 0; v < 200; v++) begin
      a = W'($urandom); b = W'($urandom);
      drive(a, b, 1'(v));
      checkVec("R1/R2 random");
    end
    drive('1, '1, 1'b1);  checkVec("R1 max");
    drive('1, W'(1), 1'b0); checkVec("R1 wrap");
    drive('0, '0, 1'b1);  checkVec("R2 zero cin1");

    for (int v = 0; v < 20; v++) begin
      a = (v == 0) ? '0 : W'($urandom);
      drive(a, ~a, 1'b0);
      check(sum == '1 && !carryOut, "R3 inverse cin0", 64'({carryOut, sum}), 64'({1'b0, {W{1'b1}}}));
      drive(a, ~a, 1'b1);
      check(sum == '0 && carryOut, "R4 inverse cin1", 64'({carryOut, sum}), 64'({1'b1, {W{1'b0}}}));
    end

    for (int v = 0; v < 40; v++) begin
      a = W'($urandom); b = (v < 4) ? ~a ^ W'(1 << (v * 5)) : W'($urandom);
      drive(a, b, 1'b0); sLo = sum;
      drive(a, b, 1'b1); sHi = sum;
      expFlip = W'((a + b + W'(1)) ^ (a + b));
      check((sLo ^ sHi) == expFlip, "R5 cin flip", 64'(sLo ^ sHi), 64'(expFlip));
    end

    faultEn = 1'b0;
    for (int k = 0; k < 6; k++) begin
      faultNet = FW'(k * 13); faultStuck = 1'(k);
      a = W'($urandom); b = W'($urandom);
      drive(a, b, 1'(k >> 1));
      checkVec("R7 inject off");
    end

    faultEn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      faultNet = FW'(NETS + k * 7); faultStuck = 1'(k);
      a = W'($urandom); b = W'($urandom);
      drive(a, b, 1'(k));
      checkVec("R8 out of range");
    end

    for (int n = 0; n < NETS; n++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        faultNet = FW'(n); faultStuck = 1'(lvl);
        hit = 0;
        for (int v = 0; v < FVECS && !hit; v++) begin
          case (v)
            0: begin a = '0; b = '0; end
            1: begin a = '1; b = '1; end
            2: begin a = '1; b = '0; end
            3: begin a = 16'h5555; b = 16'hAAAA; end
            default: begin a = W'($urandom); b = W'($urandom); end
          endcase
          drive(a, b, 1'(v));
          if (errPair == 2'b00 || errPair == 2'b11) hit = 1;
        end
        check(hit, $sformatf("R6 net %0d stuck %0d detect", n, lvl), 64'(hit), 64'h1);
      end
    end
    faultEn = 1'b0;

    drive(16'h1234, 16'h4321, 1'b1); checkVec("R7 after campaign");
    fin();
  end
endmodule